// File: doc/BRIEF.md
# Binary BCH Error-Locator Solver (Inversion-Free)

This block turns the syndromes of a narrow-sense binary BCH codeword into the error-locator polynomial Lambda(x), without any division in the field. The field is chosen at run time from GF(2^12) to GF(2^15) by a two-bit select. Only the odd syndromes S1, S3, ..., S(2T-1) are written in. The even ones are made inside the block by squaring (S(2k) = S(k)^2). A start pulse then runs the binary shortcut of the inversion-free recurrence. This shortcut moves two degrees per step, so only T-1 steps are needed.

Every field product is formed bit-serially, one bit of the multiplier operand per cycle, over M_MAX cycles. All coefficient lanes work in parallel, so each step takes the same number of cycles. The result is Lambda scaled by a nonzero constant. That constant does not move the roots, so a root search further down the chain can use Lambda as it stands. The locator length is reported along with it. `done` pulses for one cycle when the result is ready.

The controller has eight states:
- IDLE: waits for `start`.
- SQR: squares into the even syndromes.
- INIT: seeds Lambda, beta, the length and the previous discrepancy.
- DISC: forms the discrepancy products.
- DEC: sums the products and latches the discrepancy.
- UPD: forms pd·Lambda and d·beta.
- CMT: writes the new Lambda, beta, length and previous discrepancy.
- FIN: raises `done`.

The transitions are:
- IDLE→SQR on `start`.
- SQR→INIT after the last square.
- INIT→DISC.
- DISC→DEC after M_MAX bit cycles.
- DEC→UPD.
- UPD→CMT after M_MAX bit cycles.
- CMT→DISC while steps remain.
- CMT→FIN after step T-1.
- FIN→IDLE.

Top module: `ibm_solver`

## Requirements
- R1: After reset `done` is low, `lam_len` is 0, coefficient 0 of `lam` is 1 and every other coefficient is 0.
- R2: While the block is in IDLE, a cycle with `syn_we` high stores `syn_val` as S(2k+1), where k = `syn_idx`. A write outside IDLE is ignored and leaves the stored odd syndromes unchanged.
- R3: `start` is acted on only in IDLE. A pulse during a run neither restarts it nor changes its result or latency.
- R4: `fld_sel` values 0,1,2,3 select m = 12,13,14,15. Each uses its own primitive polynomial: 0x1053, 0x201B, 0x4443 and 0x8003 (bit i is the coefficient of x^i).
- R5: The even syndromes are produced internally as S(2k) = S(k)^2 for k = 1..T-1. No even syndrome is ever loaded.
- R6: Initialisation sets Lambda = 1 + S1·x. If S1 = 0, then pd = 1, beta = x^3 and length 0. Otherwise pd = S1, beta = x^2 and length 1.
- R7: Step r (r = 1..T-1) forms d = sum over i of Lambda_i·S(2r+1-i) and sets Lambda to pd·Lambda + d·beta. If d = 0 or r < length, beta becomes x^2·beta. Otherwise beta becomes x^2 times the Lambda from before the update, the length becomes 2r+1-length, and pd becomes d.
- R8: For e ≤ T distinct nonzero error locators X, the final Lambda has Lambda_0 ≠ 0 and Lambda(X^-1) = 0 for each X. Its coefficients above e are zero and `lam_len` = e.
- R9: When the three locators have X1+X2+X3 = 0 (so S1 = 0), the result still has length 3 and the right roots.
- R10: With no errors (all syndromes zero) the result is Lambda = 1 with length 0.
- R11: `done` is high for exactly one cycle. It rises (T-1)·(3·M_MAX+2)+1 clock edges after the edge that samples `start`, whatever the field.
- R12: `lam` and `lam_len` hold their values after `done` until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| fld_sel | input | 2 | Field select: m = 12 + fld_sel |
| syn_we | input | 1 | Odd-syndrome write strobe (IDLE only) |
| syn_idx | input | $clog2(T) | k of the written syndrome S(2k+1) |
| syn_val | input | M_MAX | Syndrome value, field element |
| start | input | 1 | Begin a solve (IDLE only) |
| lam | output | (T+1)·M_MAX | Lambda coefficients; coefficient i at bits i·M_MAX upward |
| lam_len | output | $clog2(2T) | Locator length register |
| done | output | 1 | One-cycle pulse, result ready |

## Verification
The bench builds the syndromes itself from chosen error locators, using its own field arithmetic. It judges Lambda only by its roots, its degree and its length. This accepts any constant scaling and rejects any wrong recurrence.

The test cases are:
- zero errors, which checks the trivial result;
- one error, where no step changes Lambda;
- two and three errors with S1 ≠ 0, the ordinary updates;
- three errors whose sum is zero, the S1 = 0 start path;
- T errors, which exercises every length change.

Each case uses a different field select, so a wrong polynomial or degree shows up as lost roots. One run is disturbed by a write and a start in mid-flight. A second run is then made without reloading, which shows that the stored syndromes were untouched.

// File: rtl/ibm_pkg.sv
package ibm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE, ST_SQR, ST_INIT, ST_DISC, ST_DEC, ST_UPD, ST_CMT, ST_FIN
    } bm_state_e;

    localparam int FSEL_W   = 2;
    localparam int FIELD_HI = 15;

    // primitive polynomial per field select, bit i = coefficient of x^i
    function automatic logic [FIELD_HI:0] fld_poly(input logic [FSEL_W-1:0] sel);
        logic [FIELD_HI:0] p;
        unique case (sel)
            2'd0:    p = 16'h1053;
            2'd1:    p = 16'h201B;
            2'd2:    p = 16'h4443;
            default: p = 16'h8003;
        endcase
        return p;
    endfunction

    function automatic int fld_deg(input logic [FSEL_W-1:0] sel);
        return 12 + int'(sel);
    endfunction

endpackage

// File: rtl/ibm_gf_step.sv
// One MSB-first step of a bit-serial field multiply: acc*x + ybit*a, reduced.
module ibm_gf_step #(
    parameter int MW = 15,
    localparam int DW = $clog2(MW + 1)
) (
    input  logic [MW-1:0] acc,
    input  logic [MW-1:0] xa,
    input  logic          ybit,
    input  logic [MW:0]   poly,
    input  logic [DW-1:0] deg,
    output logic [MW-1:0] nxt
);
    logic [MW:0] sh;

    always_comb begin
        sh = {acc, 1'b0};
        if (sh[deg]) begin
            sh = sh ^ poly;
        end
        nxt = sh[MW-1:0] ^ (ybit ? xa : '0);
    end
endmodule

// File: rtl/ibm_lane.sv
// One coefficient lane: two independent bit-serial multipliers.
module ibm_lane #(
    parameter int MW = 15,
    localparam int DW = $clog2(MW + 1),
    localparam int BW = $clog2(MW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          first,
    input  logic [BW-1:0] bidx,
    input  logic [MW-1:0] ax,
    input  logic [MW-1:0] ay,
    input  logic [MW-1:0] bx,
    input  logic [MW-1:0] by,
    input  logic [MW:0]   poly,
    input  logic [DW-1:0] deg,
    output logic [MW-1:0] pa,
    output logic [MW-1:0] pb
);
    logic [MW-1:0] acc_a, acc_b, src_a, src_b, nxt_a, nxt_b;

    assign src_a = first ? '0 : acc_a;
    assign src_b = first ? '0 : acc_b;

    ibm_gf_step #(.MW(MW)) u_ma (
        .acc(src_a), .xa(ax), .ybit(ay[bidx]), .poly(poly), .deg(deg), .nxt(nxt_a)
    );
    ibm_gf_step #(.MW(MW)) u_mb (
        .acc(src_b), .xa(bx), .ybit(by[bidx]), .poly(poly), .deg(deg), .nxt(nxt_b)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_a <= '0;
            acc_b <= '0;
        end else if (run) begin
            acc_a <= nxt_a;
            acc_b <= nxt_b;
        end
    end

    assign pa = acc_a;
    assign pb = acc_b;
endmodule

// File: rtl/ibm_fsm.sv
module ibm_fsm
    import ibm_pkg::*;
#(
    parameter int T  = 40,
    parameter int MW = 15,
    localparam int BW = $clog2(MW),
    localparam int KW = $clog2(T + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output bm_state_e     state,
    output logic [BW-1:0] bit_cnt,
    output logic [KW-1:0] sq_k,
    output logic [KW-1:0] iter,
    output logic          done
);
    bm_state_e nstate;
    logic      last_bit;

    assign last_bit = (bit_cnt == BW'(MW - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nstate;
    end

    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE: if (start) nstate = ST_SQR;
            ST_SQR:  if (last_bit && sq_k == KW'(T - 1)) nstate = ST_INIT;
            ST_INIT: nstate = ST_DISC;
            ST_DISC: if (last_bit) nstate = ST_DEC;
            ST_DEC:  nstate = ST_UPD;
            ST_UPD:  if (last_bit) nstate = ST_CMT;
            ST_CMT:  nstate = (iter == KW'(T - 1)) ? ST_FIN : ST_DISC;
            ST_FIN:  nstate = ST_IDLE;
            default: nstate = ST_IDLE;
        endcase
    end

    always_comb begin
        done = (state == ST_FIN);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            sq_k    <= KW'(1);
            iter    <= KW'(1);
        end else begin
            unique case (state)
                ST_IDLE: begin
                    bit_cnt <= '0;
                    sq_k    <= KW'(1);
                    iter    <= KW'(1);
                end
                ST_SQR: begin
                    bit_cnt <= last_bit ? '0 : bit_cnt + 1'b1;
                    if (last_bit) sq_k <= sq_k + 1'b1;
                end
                ST_DISC, ST_UPD: bit_cnt <= last_bit ? '0 : bit_cnt + 1'b1;
                ST_CMT:  if (iter != KW'(T - 1)) iter <= iter + 1'b1;
                default: bit_cnt <= '0;
            endcase
        end
    end

    p_launch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start) |=> (state == ST_SQR));
    p_no_relaunch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && state != ST_SQR) |=> (state != ST_SQR));
    p_done_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_bit_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= BW'(MW - 1));
    p_iter_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (iter >= KW'(1)) && (iter <= KW'(T - 1)));
endmodule

// File: rtl/ibm_solver.sv
module ibm_solver
    import ibm_pkg::*;
#(
    parameter int T     = 40,
    parameter int M_MAX = 15,
    localparam int IW = (T > 1) ? $clog2(T) : 1,
    localparam int LW = $clog2(2 * T),
    localparam int BW = $clog2(M_MAX),
    localparam int DW = $clog2(M_MAX + 1),
    localparam int KW = $clog2(T + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [FSEL_W-1:0]      fld_sel,
    input  logic                   syn_we,
    input  logic [IW-1:0]          syn_idx,
    input  logic [M_MAX-1:0]       syn_val,
    input  logic                   start,
    output logic [(T+1)*M_MAX-1:0] lam,
    output logic [LW-1:0]          lam_len,
    output logic                   done
);
    bm_state_e     state;
    logic [BW-1:0] bit_cnt, bidx;
    logic [KW-1:0] sq_k, iter;

    logic [M_MAX-1:0] sodd  [T];
    logic [M_MAX-1:0] seven [T];
    logic [M_MAX-1:0] lam_r [T+1];
    logic [M_MAX-1:0] beta_r[T+1];
    logic [M_MAX-1:0] beta_ini[T+1];
    logic [M_MAX-1:0] beta_nxt[T+1];
    logic [M_MAX-1:0] pa [T+1];
    logic [M_MAX-1:0] pb [T+1];
    logic [M_MAX-1:0] ysel [T+1];
    logic [M_MAX-1:0] pd_r, d_r, disc_sum, sq_acc, sq_src, sq_nxt;
    logic [LW-1:0]    len_r;
    logic [M_MAX:0]   poly;
    logic [DW-1:0]    deg;
    logic             first, run, keep, s1z;

    assign poly  = (M_MAX+1)'(fld_poly(fld_sel));
    assign deg   = DW'(fld_deg(fld_sel));
    assign bidx  = BW'(M_MAX - 1) - bit_cnt;
    assign first = (bit_cnt == '0);
    assign run   = (state == ST_DISC) || (state == ST_UPD);
    assign s1z   = (sodd[0] == '0);

    ibm_fsm #(.T(T), .MW(M_MAX)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .state(state),
        .bit_cnt(bit_cnt), .sq_k(sq_k), .iter(iter), .done(done)
    );

    // even syndrome source for the squaring pass
    always_comb begin
        if (sq_k[0]) sq_src = sodd[IW'((int'(sq_k) - 1) / 2)];
        else         sq_src = seven[IW'(int'(sq_k) / 2)];
    end

    ibm_gf_step #(.MW(M_MAX)) u_sq (
        .acc(first ? '0 : sq_acc), .xa(sq_src), .ybit(sq_src[bidx]),
        .poly(poly), .deg(deg), .nxt(sq_nxt)
    );

    genvar gi;
    generate
        for (gi = 0; gi <= T; gi++) begin : g_lane
            always_comb begin
                int j;
                j = 2 * int'(iter) + 1 - gi;
                if (j < 1 || j > 2 * T - 1) ysel[gi] = '0;
                else if (j % 2 == 1)        ysel[gi] = sodd[IW'((j - 1) / 2)];
                else                        ysel[gi] = seven[IW'(j / 2)];
            end

            ibm_lane #(.MW(M_MAX)) u_lane (
                .clk(clk), .rst_n(rst_n), .run(run), .first(first), .bidx(bidx),
                .ax(lam_r[gi]), .ay((state == ST_DISC) ? ysel[gi] : pd_r),
                .bx(beta_r[gi]), .by(d_r), .poly(poly), .deg(deg),
                .pa(pa[gi]), .pb(pb[gi])
            );

            assign lam[gi*M_MAX +: M_MAX] = lam_r[gi];
        end
    endgenerate

    always_comb begin
        disc_sum = '0;
        for (int i = 0; i <= T; i++) disc_sum = disc_sum ^ pa[i];
    end

    assign keep = (d_r == '0) || (int'(iter) < int'(len_r));

    always_comb begin
        for (int i = 0; i <= T; i++) begin
            beta_ini[i] = (i == (s1z ? 3 : 2)) ? M_MAX'(1) : '0;
        end
        beta_nxt[0] = '0;
        beta_nxt[1] = '0;
        for (int i = 2; i <= T; i++) begin
            beta_nxt[i] = keep ? beta_r[i-2] : lam_r[i-2];
        end
    end

    // syndrome store
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < T; i++) begin
                sodd[i]  <= '0;
                seven[i] <= '0;
            end
            sq_acc <= '0;
        end else begin
            if (state == ST_IDLE && syn_we) sodd[syn_idx] <= syn_val;
            if (state == ST_SQR) begin
                sq_acc <= sq_nxt;
                if (bit_cnt == BW'(M_MAX - 1)) seven[IW'(sq_k)] <= sq_nxt;
            end
        end
    end

    // polynomial state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i <= T; i++) begin
                lam_r[i]  <= (i == 0) ? M_MAX'(1) : '0;
                beta_r[i] <= '0;
            end
            pd_r  <= M_MAX'(1);
            d_r   <= '0;
            len_r <= '0;
        end else begin
            unique case (state)
                ST_INIT: begin
                    for (int i = 0; i <= T; i++) begin
                        lam_r[i]  <= (i == 0) ? M_MAX'(1) : ((i == 1) ? sodd[0] : '0);
                        beta_r[i] <= beta_ini[i];
                    end
                    pd_r  <= s1z ? M_MAX'(1) : sodd[0];
                    len_r <= s1z ? '0 : LW'(1);
                end
                ST_DEC: d_r <= disc_sum;
                ST_CMT: begin
                    for (int i = 0; i <= T; i++) begin
                        lam_r[i]  <= pa[i] ^ pb[i];
                        beta_r[i] <= beta_nxt[i];
                    end
                    if (!keep) begin
                        pd_r  <= d_r;
                        len_r <= LW'(2 * int'(iter) + 1 - int'(len_r));
                    end
                end
                default: ;
            endcase
        end
    end

    assign lam_len = len_r;

    p_pd_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pd_r != '0);
    p_len_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        int'(len_r) <= 2 * T - 1);
    p_odd_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> (sodd[0] == $past(sodd[0])));
    p_lam_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !start) |=> $stable(lam) && $stable(lam_len));
endmodule

// File: tb/sim_ibm_solver.sv
module sim_ibm_solver;
    localparam int CLK_NS = 10;
    localparam int T  = 4;
    localparam int M  = 15;
    localparam int IW = $clog2(T);
    localparam int LW = $clog2(2 * T);
    localparam int LAT = (T - 1) * (3 * M + 2) + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] fld_sel = '0;
    logic syn_we = 1'b0;
    logic [IW-1:0] syn_idx = '0;
    logic [M-1:0] syn_val = '0;
    logic start = 1'b0;
    logic [(T+1)*M-1:0] lam;
    logic [LW-1:0] lam_len;
    logic done;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    always #(CLK_NS/2) clk = ~clk;
    always @(posedge clk) cyc++;

    ibm_solver #(.T(T), .M_MAX(M)) u0 (
        .clk(clk), .rst_n(rst_n), .fld_sel(fld_sel), .syn_we(syn_we),
        .syn_idx(syn_idx), .syn_val(syn_val), .start(start),
        .lam(lam), .lam_len(lam_len), .done(done)
    );

    function automatic int poly_of(int sel);
        case (sel)
            0: return 'h1053;
            1: return 'h201B;
            2: return 'h4443;
            default: return 'h8003;
        endcase
    endfunction

    function automatic int gmul(int a, int b, int sel);
        int m = 12 + sel;
        int r = 0;
        for (int i = m - 1; i >= 0; i--) begin
            r = r << 1;
            if ((r >> m) & 1) r = r ^ poly_of(sel);
            if ((b >> i) & 1) r = r ^ a;
        end
        return r;
    endfunction

    function automatic int gpow(int a, int e, int sel);
        int r = 1;
        for (int i = 0; i < e; i++) r = gmul(r, a, sel);
        return r;
    endfunction

    function automatic int coef(int k);
        return int'(lam[k*M +: M]);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // drives one solve and checks roots, degree, length and latency
    task automatic run_case(input string req, input int sel, input int ne,
                            input int x0, input int x1, input int x2, input int x3,
                            input bit reload, input bit disturb);
        int xs[4];
        int n;
        int s;
        int acc;
        logic [(T+1)*M-1:0] snap;
        xs[0] = x0; xs[1] = x1; xs[2] = x2; xs[3] = x3;
        @(negedge clk);
        fld_sel = 2'(sel);
        if (reload) begin
            for (int k = 0; k < T; k++) begin
                s = 0;
                for (int e = 0; e < ne; e++) s = s ^ gpow(xs[e], 2 * k + 1, sel);
                syn_we = 1'b1; syn_idx = IW'(k); syn_val = M'(s);
                @(negedge clk);
            end
            syn_we = 1'b0;
        end
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        n = 0;
        while (!done && n < 5000) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (disturb && n == 20) begin
                syn_we = 1'b1; syn_idx = '0; syn_val = M'('h1234); start = 1'b1;
            end else if (disturb && n == 21) begin
                syn_we = 1'b0; start = 1'b0;
            end
        end
        chk(n == LAT, "R11", {req, " latency"}, n, LAT);
        chk(int'(lam_len) == ne, req, "length", lam_len, ne);
        chk(coef(0) != 0, "R8", {req, " lambda0 nonzero"}, coef(0), 1);
        for (int e = 0; e < ne; e++) begin
            acc = 0;
            for (int k = 0; k <= T; k++) acc = acc ^ gmul(coef(k), gpow(xs[e], T - k, sel), sel);
            chk(acc == 0, req, "root at error locator", acc, 0);
        end
        for (int k = ne + 1; k <= T; k++) chk(coef(k) == 0, req, "coef above degree", coef(k), 0);
        if (ne > 0) chk(coef(ne) != 0, req, "leading coef", coef(ne), 1);
        snap = lam;
        @(negedge clk);
        chk(!done, "R11", "done one cycle", done, 0);
        repeat (4) @(negedge clk);
        chk(lam == snap, "R12", "lam held", 0, 0);
    endtask

    task automatic test_reset();
        chk(done == 1'b0, "R1", "done at reset", done, 0);
        chk(lam_len == '0, "R1", "len at reset", lam_len, 0);
        chk(coef(0) == 1, "R1", "coef0 at reset", coef(0), 1);
        for (int k = 1; k <= T; k++) chk(coef(k) == 0, "R1", "coef at reset", coef(k), 0);
    endtask

    task automatic test_none();
        run_case("R10", 0, 0, 0, 0, 0, 0, 1'b1, 1'b0);
        chk(coef(0) == 1, "R10", "lambda exactly 1", coef(0), 1);
    endtask

    initial begin
        #(CLK_NS * 200000);
        bad++; total++;
        $display("FAIL watchdog actual=expired expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        test_none();
        run_case("R6", 1, 1, 'h1ABC, 0, 0, 0, 1'b1, 1'b0);                 // single error, m=13
        run_case("R5", 2, 2, 'h2345, 'h0777, 0, 0, 1'b1, 1'b0);           // m=14, uses squares
        run_case("R4", 3, 3, 'h7001, 'h1234, 'h0042, 0, 1'b1, 1'b0);      // m=15
        run_case("R9", 0, 3, 'h0003, 'h0005, 'h0006, 0, 1'b1, 1'b0);      // S1 = 0 path
        run_case("R7", 1, 4, 'h0011, 'h1F00, 'h0ABC, 'h1357, 1'b1, 1'b0); // e = T
        run_case("R3", 2, 2, 'h0101, 'h3003, 0, 0, 1'b1, 1'b1);           // disturbed run
        run_case("R2", 2, 2, 'h0101, 'h3003, 0, 0, 1'b0, 1'b0);           // no reload: store intact
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule